// File: doc/BRIEF.md
# Halt-Mode Standby Controller

This block takes the CPU from normal execution into one of three low-power halt states and back. A one-cycle halt strobe starts entry into the state chosen by a stored two-bit mode field. The light state stops only the CPU. The middle state also stops the peripherals and keeps the oscillator running. The deep state stops the oscillator as well. Entry into the middle and deep states takes a fixed number of cycles. A wake request that arrives during those cycles is held as pending and acts as soon as entry completes.

While halted, the block checks each incoming interrupt request against the CPU's current mask level and decides whether to wake. A request whose level is above the mask wakes the CPU and is serviced. The non-maskable class always wakes and is serviced. A wake-capable class (the external pins and the clock timer) wakes even when masked; the CPU then resumes after the halt and the request flag is kept. Any other masked request is ignored. The request strobe passes through a synchroniser, so sampling is asynchronous and the exit is aligned to the clock. Leaving the deep state first starts the warm-up timer and waits for it to finish. At that point the block records whether the system resumes on the slow clock.

Top module: `halt_standby_ctrl`

## Requirements
- R1: After reset all stop, warm-up and wake outputs are 0, sys_slow_o is 0, and the stored mode field is 2'b11, so a halt strobe with no prior configuration write enters the light state.
- R2: A halt strobe with mode 2'b11 or 2'b00 sets cpu_stop_o in the next cycle, and periph_stop_o and osc_stop_o stay 0 for the whole halt.
- R3: With mode 2'b10, only cpu_stop_o is 1 during the ENTRY_CYCLES entry cycles. After entry, cpu_stop_o and periph_stop_o are 1 and osc_stop_o is 0.
- R4: With mode 2'b01, after the ENTRY_CYCLES entry cycles, cpu_stop_o, periph_stop_o and osc_stop_o are all 1.
- R5: While halted, a request whose level is strictly greater than mask_lvl_i produces a one-cycle wake_o pulse with wake_service_o=1 and flag_hold_o=0, and cpu_stop_o is 0 in that same cycle.
- R6: While halted, a request that is not non-maskable, whose level is at most mask_lvl_i and whose irq_wake_any_i is 0, produces no wake, and all stop outputs keep their values.
- R7: While halted, a masked request with irq_wake_any_i=1 wakes the CPU with wake_service_o=0 and flag_hold_o=1.
- R8: A request with irq_nmi_i=1 wakes the CPU with wake_service_o=1 whatever its level and mask, including mask 7.
- R9: A wake in the deep state drops osc_stop_o and pulses wu_start_o for one cycle. cpu_stop_o and periph_stop_o stay 1 and wake_o stays 0 until wu_done_i. wake_o then follows in the next cycle, and sys_slow_o takes the value of resume_slow_i.
- R10: A qualifying request that arrives during entry is held pending. The device still reaches the selected halt state for at least one cycle and then wakes without further input.
- R11: irq_req_i passes through SYNC_STAGES flops. When the request is raised in a halt state, wake_o rises SYNC_STAGES+1 cycles later.
- R12: Asserting rst_ni low in any halt state forces all stop outputs to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running oscillator-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the stored halt-mode field |
| cfg_mode_i | input | 2 | New mode: 11/00 light, 10 middle, 01 deep |
| halt_i | input | 1 | One-cycle halt command from the CPU |
| mask_lvl_i | input | LVL_W | Current CPU interrupt mask level |
| irq_req_i | input | 1 | Interrupt request present (asynchronous) |
| irq_lvl_i | input | LVL_W | Priority level of the request |
| irq_nmi_i | input | 1 | Request is non-maskable |
| irq_wake_any_i | input | 1 | Request is of the class that wakes even when masked |
| resume_slow_i | input | 1 | Resume on the slow clock after the deep state |
| wu_done_i | input | 1 | Warm-up timer has expired |
| cpu_stop_o | output | 1 | Stop CPU execution |
| periph_stop_o | output | 1 | Stop peripheral clocks |
| osc_stop_o | output | 1 | Stop the main oscillator |
| wu_start_o | output | 1 | One-cycle start of the warm-up timer |
| wake_o | output | 1 | One-cycle halt exit pulse |
| wake_service_o | output | 1 | Meaningful with wake_o: 1 service the interrupt, 0 resume |
| flag_hold_o | output | 1 | Meaningful with wake_o: the request flag stays set |
| sys_slow_o | output | 1 | System runs on the slow clock after a deep-state exit |

## Verification
The checks assume that irq_lvl_i, irq_nmi_i and irq_wake_any_i stay steady while irq_req_i is high, because only the request strobe is synchronised. They also assume that wu_done_i is pulsed only after wu_start_o. The bench changes a request's class and level only after it has dropped irq_req_i and let the synchroniser drain. It raises wu_done_i only after it has seen the warm-up start pulse. It issues halt strobes only while the CPU is running.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam logic [1:0] MODE_LIGHT = 2'b11;
  localparam logic [1:0] MODE_ALT   = 2'b00;
  localparam logic [1:0] MODE_MID   = 2'b10;
  localparam logic [1:0] MODE_DEEP  = 2'b01;

  typedef enum logic [2:0] {
    ST_RUN, ST_ENTER, ST_LIGHT, ST_MID, ST_DEEP, ST_WARM
  } hsc_state_e;

  typedef struct packed {
    logic wake;
    logic service;
    logic hold;
  } wake_dec_t;
endpackage

// File: rtl/hsc_req_sync.sv
module hsc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsc_wake_eval.sv
module hsc_wake_eval
  import hsc_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             req_i,
  input  logic             nmi_i,
  input  logic             wake_any_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] mask_i,
  output wake_dec_t        dec_o
);
  logic above;
  assign above = nmi_i || (lvl_i > mask_i);

  always_comb begin
    dec_o.wake    = req_i && (above || wake_any_i);
    dec_o.service = above;
    dec_o.hold    = !above;
  end
endmodule

// File: rtl/hsc_fsm.sv
module hsc_fsm
  import hsc_pkg::*;
#(
  parameter int ENTRY_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic [1:0] mode_i,
  input  wake_dec_t  dec_i,
  input  logic       resume_slow_i,
  input  logic       wu_done_i,
  output logic       cpu_stop_o,
  output logic       periph_stop_o,
  output logic       osc_stop_o,
  output logic       wu_start_o,
  output logic       wake_o,
  output logic       wake_service_o,
  output logic       flag_hold_o,
  output logic       sys_slow_o
);
  localparam int CNT_W = (ENTRY_CYCLES > 1) ? $clog2(ENTRY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ENTRY_CYCLES - 1);

  hsc_state_e       state_q, tgt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, pend_svc_q, pend_hold_q;
  logic             go, go_svc, go_hold;

  // pending decision wins over a live one
  assign go      = pend_q || dec_i.wake;
  assign go_svc  = pend_q ? pend_svc_q  : dec_i.service;
  assign go_hold = pend_q ? pend_hold_q : dec_i.hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_RUN;
      tgt_q          <= ST_MID;
      cnt_q          <= '0;
      pend_q         <= 1'b0;
      pend_svc_q     <= 1'b0;
      pend_hold_q    <= 1'b0;
      wu_start_o     <= 1'b0;
      wake_o         <= 1'b0;
      wake_service_o <= 1'b0;
      flag_hold_o    <= 1'b0;
      sys_slow_o     <= 1'b0;
    end else begin
      wu_start_o <= 1'b0;
      wake_o     <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (halt_i) begin
            pend_q <= 1'b0;
            if (mode_i == MODE_MID || mode_i == MODE_DEEP) begin
              state_q <= ST_ENTER;
              cnt_q   <= CNT_LOAD;
              tgt_q   <= (mode_i == MODE_DEEP) ? ST_DEEP : ST_MID;
            end else begin
              state_q <= ST_LIGHT;
            end
          end
        end
        ST_ENTER: begin
          if (dec_i.wake && !pend_q) begin
            pend_q      <= 1'b1;
            pend_svc_q  <= dec_i.service;
            pend_hold_q <= dec_i.hold;
          end
          if (cnt_q == '0) state_q <= tgt_q;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_LIGHT, ST_MID: begin
          if (go) begin
            state_q        <= ST_RUN;
            wake_o         <= 1'b1;
            wake_service_o <= go_svc;
            flag_hold_o    <= go_hold;
            pend_q         <= 1'b0;
          end
        end
        ST_DEEP: begin
          if (go) begin
            state_q     <= ST_WARM;
            wu_start_o  <= 1'b1;
            pend_q      <= 1'b1;
            pend_svc_q  <= go_svc;
            pend_hold_q <= go_hold;
          end
        end
        ST_WARM: begin
          if (wu_done_i) begin
            state_q        <= ST_RUN;
            wake_o         <= 1'b1;
            wake_service_o <= pend_svc_q;
            flag_hold_o    <= pend_hold_q;
            pend_q         <= 1'b0;
            sys_slow_o     <= resume_slow_i;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    cpu_stop_o    = (state_q != ST_RUN);
    periph_stop_o = (state_q == ST_MID) || (state_q == ST_DEEP) || (state_q == ST_WARM);
    osc_stop_o    = (state_q == ST_DEEP);
  end
endmodule

// File: rtl/halt_standby_ctrl.sv
module halt_standby_ctrl
  import hsc_pkg::*;
#(
  parameter int LVL_W        = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             halt_i,
  input  logic [LVL_W-1:0] mask_lvl_i,
  input  logic             irq_req_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             irq_nmi_i,
  input  logic             irq_wake_any_i,
  input  logic             resume_slow_i,
  input  logic             wu_done_i,
  output logic             cpu_stop_o,
  output logic             periph_stop_o,
  output logic             osc_stop_o,
  output logic             wu_start_o,
  output logic             wake_o,
  output logic             wake_service_o,
  output logic             flag_hold_o,
  output logic             sys_slow_o
);
  logic [1:0] mode_q;
  logic       req_sync;
  wake_dec_t  dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_LIGHT;
    else if (cfg_we_i) mode_q <= cfg_mode_i;
  end

  hsc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_req_i),
    .q_o   (req_sync)
  );

  hsc_wake_eval #(.LVL_W(LVL_W)) u_eval (
    .req_i     (req_sync),
    .nmi_i     (irq_nmi_i),
    .wake_any_i(irq_wake_any_i),
    .lvl_i     (irq_lvl_i),
    .mask_i    (mask_lvl_i),
    .dec_o     (dec)
  );

  hsc_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .halt_i        (halt_i),
    .mode_i        (mode_q),
    .dec_i         (dec),
    .resume_slow_i (resume_slow_i),
    .wu_done_i     (wu_done_i),
    .cpu_stop_o    (cpu_stop_o),
    .periph_stop_o (periph_stop_o),
    .osc_stop_o    (osc_stop_o),
    .wu_start_o    (wu_start_o),
    .wake_o        (wake_o),
    .wake_service_o(wake_service_o),
    .flag_hold_o   (flag_hold_o),
    .sys_slow_o    (sys_slow_o)
  );
endmodule

// File: rtl/hsc_chk.sv
module hsc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpu_stop_o,
  input logic periph_stop_o,
  input logic osc_stop_o,
  input logic wu_start_o,
  input logic wake_o,
  input logic wake_service_o,
  input logic flag_hold_o
);
  // R3
  periph_needs_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_stop_o |-> cpu_stop_o);
  // R4
  osc_needs_periph_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_stop_o |-> (periph_stop_o && cpu_stop_o));
  // R5
  wake_runs_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !cpu_stop_o);
  // R5
  exit_by_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_stop_o) |-> wake_o);
  // R7
  wake_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (wake_service_o != flag_hold_o));
  // R9
  osc_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_stop_o) |-> (wu_start_o && periph_stop_o && !wake_o));
  // R9
  wu_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wu_start_o |=> (!wu_start_o && !wake_o));
endmodule

bind halt_standby_ctrl hsc_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_stop_o    (cpu_stop_o),
  .periph_stop_o (periph_stop_o),
  .osc_stop_o    (osc_stop_o),
  .wu_start_o    (wu_start_o),
  .wake_o        (wake_o),
  .wake_service_o(wake_service_o),
  .flag_hold_o   (flag_hold_o)
);

// File: tb/halt_standby_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_standby_ctrl_tb_top;
  localparam int LVL_W = 3;
  localparam int SYNC  = 2;
  localparam int ENTRY = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 0, halt_i = 0, irq_req_i = 0, irq_nmi_i = 0, irq_wake_any_i = 0;
  logic resume_slow_i = 0, wu_done_i = 0;
  logic [1:0] cfg_mode_i = 2'b00;
  logic [LVL_W-1:0] mask_lvl_i = '0, irq_lvl_i = '0;
  logic cpu_stop_o, periph_stop_o, osc_stop_o, wu_start_o, wake_o;
  logic wake_service_o, flag_hold_o, sys_slow_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  halt_standby_ctrl #(.LVL_W(LVL_W), .SYNC_STAGES(SYNC), .ENTRY_CYCLES(ENTRY)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .halt_i(halt_i), .mask_lvl_i(mask_lvl_i), .irq_req_i(irq_req_i), .irq_lvl_i(irq_lvl_i),
    .irq_nmi_i(irq_nmi_i), .irq_wake_any_i(irq_wake_any_i), .resume_slow_i(resume_slow_i),
    .wu_done_i(wu_done_i), .cpu_stop_o(cpu_stop_o), .periph_stop_o(periph_stop_o),
    .osc_stop_o(osc_stop_o), .wu_start_o(wu_start_o), .wake_o(wake_o),
    .wake_service_o(wake_service_o), .flag_hold_o(flag_hold_o), .sys_slow_o(sys_slow_o));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_mode(input logic [1:0] m);
    cfg_mode_i = m; cfg_we_i = 1; cyc(1); cfg_we_i = 0;
  endtask

  task automatic do_halt();
    halt_i = 1; cyc(1); halt_i = 0;
  endtask

  task automatic drop_irq();
    irq_req_i = 0; irq_nmi_i = 0; irq_wake_any_i = 0; cyc(SYNC + 2);
  endtask

  task automatic wait_wake(input int max, output int n, output bit got, output bit saw_mid);
    got = 0; n = 0; saw_mid = 0;
    while (!got && n < max) begin
      cyc(1); n++;
      if (periph_stop_o && !osc_stop_o && !wake_o) saw_mid = 1;
      if (wake_o) got = 1;
    end
  endtask

  task automatic t_reset();
    chk({cpu_stop_o, periph_stop_o, osc_stop_o, wu_start_o, wake_o, sys_slow_o} == 6'b0,
        "R1 reset outputs", {cpu_stop_o, periph_stop_o, osc_stop_o}, 0);
  endtask

  task automatic t_light_default();
    int n; bit g, s;
    do_halt();
    chk(cpu_stop_o == 1, "R1 default mode halts cpu", cpu_stop_o, 1);
    chk(periph_stop_o == 0, "R2 light state periph", periph_stop_o, 0);
    cyc(ENTRY + 4);
    chk({periph_stop_o, osc_stop_o} == 2'b00, "R2 light state stays light",
        {periph_stop_o, osc_stop_o}, 0);
    mask_lvl_i = 3'd2; irq_lvl_i = 3'd5; irq_req_i = 1;
    wait_wake(20, n, g, s);
    chk(g, "R5 unmasked wake", g, 1);
    chk(n == SYNC + 1, "R11 wake latency", n, SYNC + 1);
    chk(wake_service_o == 1 && flag_hold_o == 0, "R5 service kind",
        {wake_service_o, flag_hold_o}, 2);
    chk(cpu_stop_o == 0, "R5 cpu runs at wake", cpu_stop_o, 0);
    drop_irq();
  endtask

  task automatic t_mode00_nmi();
    int n; bit g, s;
    set_mode(2'b00);
    do_halt();
    cyc(ENTRY + 2);
    chk({cpu_stop_o, periph_stop_o} == 2'b10, "R2 mode 00 is light",
        {cpu_stop_o, periph_stop_o}, 2);
    mask_lvl_i = 3'd7; irq_lvl_i = 3'd0; irq_nmi_i = 1; irq_req_i = 1;
    wait_wake(20, n, g, s);
    chk(g && wake_service_o, "R8 nmi wakes at mask 7", {g, wake_service_o}, 3);
    drop_irq();
  endtask

  task automatic t_mid();
    int n; bit g, s;
    set_mode(2'b10);
    do_halt();
    chk({cpu_stop_o, periph_stop_o} == 2'b10, "R3 entry stops cpu only",
        {cpu_stop_o, periph_stop_o}, 2);
    cyc(ENTRY);
    chk({cpu_stop_o, periph_stop_o, osc_stop_o} == 3'b110, "R3 middle state",
        {cpu_stop_o, periph_stop_o, osc_stop_o}, 6);
    mask_lvl_i = 3'd3; irq_lvl_i = 3'd3; irq_req_i = 1;
    wait_wake(12, n, g, s);
    chk(!g, "R6 masked request ignored", g, 0);
    chk({cpu_stop_o, periph_stop_o, osc_stop_o} == 3'b110, "R6 state kept",
        {cpu_stop_o, periph_stop_o, osc_stop_o}, 6);
    irq_wake_any_i = 1;
    wait_wake(20, n, g, s);
    chk(g && !wake_service_o && flag_hold_o, "R7 masked wake-any resumes",
        {g, wake_service_o, flag_hold_o}, 5);
    drop_irq();
  endtask

  task automatic t_deep();
    int n; bit g, s;
    set_mode(2'b01);
    do_halt();
    cyc(ENTRY);
    chk({cpu_stop_o, periph_stop_o, osc_stop_o} == 3'b111, "R4 deep state",
        {cpu_stop_o, periph_stop_o, osc_stop_o}, 7);
    mask_lvl_i = 3'd1; irq_lvl_i = 3'd6; irq_req_i = 1;
    n = 0;
    while (!wu_start_o && n < 20) begin cyc(1); n++; end
    chk(wu_start_o == 1, "R9 warm-up start", wu_start_o, 1);
    chk({cpu_stop_o, periph_stop_o, osc_stop_o} == 3'b110, "R9 osc restarts",
        {cpu_stop_o, periph_stop_o, osc_stop_o}, 6);
    cyc(1);
    chk(wu_start_o == 0, "R9 start is one pulse", wu_start_o, 0);
    cyc(5);
    chk(!wake_o && cpu_stop_o, "R9 no wake before warm-up", {wake_o, cpu_stop_o}, 1);
    resume_slow_i = 1; wu_done_i = 1; cyc(1); wu_done_i = 0;
    chk(wake_o && wake_service_o, "R9 wake after warm-up", {wake_o, wake_service_o}, 3);
    chk(sys_slow_o == 1, "R9 slow clock resume", sys_slow_o, 1);
    resume_slow_i = 0;
    drop_irq();
  endtask

  task automatic t_pending();
    int n; bit g, s;
    set_mode(2'b10);
    mask_lvl_i = 3'd0; irq_lvl_i = 3'd7;
    halt_i = 1; irq_req_i = 1; cyc(1); halt_i = 0;
    wait_wake(30, n, g, s);
    chk(g, "R10 pending wake", g, 1);
    chk(s, "R10 middle state reached before wake", s, 1);
    drop_irq();
  endtask

  task automatic t_reset_in_deep();
    set_mode(2'b01);
    do_halt();
    cyc(ENTRY + 1);
    #1 rst_ni = 0;
    #0.5;
    chk({cpu_stop_o, periph_stop_o, osc_stop_o} == 3'b000, "R12 reset releases halt",
        {cpu_stop_o, periph_stop_o, osc_stop_o}, 0);
    cyc(1); rst_ni = 1; cyc(1);
  endtask

  initial begin
    cyc(3); rst_ni = 1; cyc(1);
    t_reset();
    t_light_default();
    t_mode00_nmi();
    t_mid();
    t_deep();
    t_pending();
    t_reset_in_deep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule